// File: doc/BRIEF.md
# Programmable CRC-32 Accelerator

This block computes a running 32-bit CRC over data that software pushes into it through a small register bus. Software first writes a configuration word. That word chooses the starting value, the width of each data write (a whole word or a single byte), whether each input byte is bit-mirrored, whether each byte of the result is bit-mirrored, and whether the result is complemented. Software then writes data into the data-input register one item at a time. Each write advances the CRC by one clock-cycle update using the fixed generator polynomial 0x04C11DB7.

A seed register holds a programmable starting value. The starting value is applied only on the first data write after a configuration write. The start-selection field then clears itself, and later data writes keep accumulating. The result register holds the post-processed CRC. It is refreshed on the clock edge that takes each data write.

Top module: `crc_accel`

## Requirements
- R1: After reset the configuration register reads 0, the seed register reads 0 and the result register reads 0.
- R2: The configuration register (address 0x0) keeps only bits 14:13 (start select), 12 (size), 9 (complement), 8 (output mirror) and 7 (input mirror). Every other bit reads back as zero, so writing all ones reads back 0x00007380.
- R3: On the first data write after a configuration write, the starting value depends on the start-select field. Code 0 takes the seed register, code 2 takes all zeros, code 3 takes all ones, and code 1 keeps the current running CRC.
- R4: A data write clears the start-select field to 0, and the field stays 0 until software writes the configuration register again. Data writes after the first one continue from the running CRC and do not restart.
- R5: With size=0 a data write (address 0x8) processes all four bytes, least-significant byte first. With size=1 it processes only bits 7:0. Each byte is shifted in MSB first into a non-reflected CRC with polynomial 0x04C11DB7, so the bytes "123456789" from start code 3 give 0x0376E6E7.
- R6: With the input-mirror bit set, the bit order of every processed input byte is reversed before it enters the CRC.
- R7: With the output-mirror bit set, the bit order within each of the four result bytes is reversed, and the bytes stay in their positions.
- R8: With the complement bit set, every result bit is inverted after any output mirroring.
- R9: A seed write (address 0x4) reads back at 0x4 and does not disturb the running CRC. The seed takes effect only through start code 0 on a later first data write.
- R10: The result register (address 0xC) is read-only, and a write to it changes nothing. The result reflects a data write from the clock edge that takes that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The checks that run every cycle cover three things. The configuration readback never shows reserved bits. A data write always clears the start-select field and the pending-start state. Seed writes and non-data cycles leave the running CRC and the result untouched.

The remaining behaviour can only be shown by the bench scenarios against an arithmetic model. This covers the CRC value itself, the least-significant-byte-first ordering, the choice of start value, the per-byte input and output mirroring, and complementing. The bench sweeps every combination of size, mirror and complement bits against every start code. It also checks a known nine-byte vector and every possible byte value.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int CRC_W   = 32;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = DATA_W / BYTE_W;
    localparam int ADDR_W  = 4;

    localparam logic [CRC_W-1:0] POLY = 32'h04C1_1DB7;

    localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_SEED = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_DIN  = 4'h8;
    localparam logic [ADDR_W-1:0] ADDR_RES  = 4'hC;

    localparam int START_LSB = 13;
    localparam int SIZE_BIT  = 12;
    localparam int CPL_BIT   = 9;
    localparam int OMIR_BIT  = 8;
    localparam int IMIR_BIT  = 7;

    localparam logic [DATA_W-1:0] CFG_MASK =
        (32'd3 << START_LSB) | (32'd1 << SIZE_BIT) | (32'd1 << CPL_BIT) |
        (32'd1 << OMIR_BIT) | (32'd1 << IMIR_BIT);

    typedef enum logic [1:0] {
        START_SEED  = 2'd0,
        START_KEEP  = 2'd1,
        START_ZEROS = 2'd2,
        START_ONES  = 2'd3
    } start_sel_e;

    typedef struct packed {
        start_sel_e start;
        logic       byte_mode;
        logic       complement;
        logic       out_mirror;
        logic       in_mirror;
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.start      = start_sel_e'(w[START_LSB +: 2]);
        c.byte_mode  = w[SIZE_BIT];
        c.complement = w[CPL_BIT];
        c.out_mirror = w[OMIR_BIT];
        c.in_mirror  = w[IMIR_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[START_LSB +: 2] = c.start;
        w[SIZE_BIT]       = c.byte_mode;
        w[CPL_BIT]        = c.complement;
        w[OMIR_BIT]       = c.out_mirror;
        w[IMIR_BIT]       = c.in_mirror;
        return w;
    endfunction

    function automatic logic [BYTE_W-1:0] mirror_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    // One byte, MSB first, non-reflected register.
    function automatic logic [CRC_W-1:0] crc_byte_step(input logic [CRC_W-1:0] c,
                                                       input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {b, {(CRC_W-BYTE_W){1'b0}}};
        for (int k = 0; k < BYTE_W; k++)
            r = r[CRC_W-1] ? ((r << 1) ^ POLY) : (r << 1);
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] pick_start(input logic pending,
                                                    input start_sel_e sel,
                                                    input logic [CRC_W-1:0] seed,
                                                    input logic [CRC_W-1:0] running);
        if (!pending) return running;
        case (sel)
            START_SEED:  return seed;
            START_ZEROS: return '0;
            START_ONES:  return '1;
            default:     return running;
        endcase
    endfunction

endpackage

// File: rtl/crc_cfg_reg.sv
module crc_cfg_reg
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              din_we,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output logic              start_pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg           <= cfg_from_word('0);
            start_pending <= 1'b1;
        end else if (cfg_we) begin
            cfg           <= cfg_from_word(wdata);
            start_pending <= 1'b1;
        end else if (din_we) begin
            cfg.start     <= START_SEED;
            start_pending <= 1'b0;
        end
    end

    // R4: start select self-clears on a data write
    a_r4_start_cleared: assert property (@(posedge clk) disable iff (rst)
        din_we |=> (cfg.start == START_SEED));

    // R4: later data writes accumulate rather than restart
    a_r4_pending_drops: assert property (@(posedge clk) disable iff (rst)
        din_we |=> !start_pending);

endmodule

// File: rtl/crc_update.sv
module crc_update
    import crc_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] din,
    input  logic              byte_mode,
    input  logic              in_mirror,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] after_first;
    logic [CRC_W-1:0] after_all;

    always_comb begin
        logic [CRC_W-1:0]  c;
        logic [BYTE_W-1:0] b;
        c = crc_in;
        after_first = '0;
        for (int i = 0; i < LANES; i++) begin
            b = din[i*BYTE_W +: BYTE_W];
            if (in_mirror) b = mirror_byte(b);
            c = crc_byte_step(c, b);
            if (i == 0) after_first = c;
        end
        after_all = c;
    end

    assign crc_out = byte_mode ? after_first : after_all;

endmodule

// File: rtl/crc_post.sv
module crc_post
    import crc_pkg::*;
(
    input  logic [CRC_W-1:0] raw,
    input  logic             out_mirror,
    input  logic             complement,
    output logic [CRC_W-1:0] shown
);

    for (genvar i = 0; i < CRC_W / BYTE_W; i++) begin : g_byte
        logic [BYTE_W-1:0] src;
        logic [BYTE_W-1:0] ordered;
        assign src     = raw[i*BYTE_W +: BYTE_W];
        assign ordered = out_mirror ? mirror_byte(src) : src;
        assign shown[i*BYTE_W +: BYTE_W] = ordered ^ {BYTE_W{complement}};
    end

endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic cfg_we, seed_we, din_we;
    cfg_t cfg;
    logic start_pending;

    logic [CRC_W-1:0] seed_q, crc_q, result_q;
    logic [CRC_W-1:0] start_val, crc_next, post_val;

    assign cfg_we  = bus_wr && (bus_addr == ADDR_CFG);
    assign seed_we = bus_wr && (bus_addr == ADDR_SEED);
    assign din_we  = bus_wr && (bus_addr == ADDR_DIN);

    crc_cfg_reg u_cfg (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .din_we        (din_we),
        .wdata         (bus_wdata),
        .cfg           (cfg),
        .start_pending (start_pending)
    );

    assign start_val = pick_start(start_pending, cfg.start, seed_q, crc_q);

    crc_update u_upd (
        .crc_in    (start_val),
        .din       (bus_wdata),
        .byte_mode (cfg.byte_mode),
        .in_mirror (cfg.in_mirror),
        .crc_out   (crc_next)
    );

    crc_post u_post (
        .raw        (crc_next),
        .out_mirror (cfg.out_mirror),
        .complement (cfg.complement),
        .shown      (post_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q   <= '0;
            crc_q    <= '0;
            result_q <= '0;
        end else begin
            if (seed_we) seed_q <= bus_wdata;
            if (din_we) begin
                crc_q    <= crc_next;
                result_q <= post_val;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CFG:  bus_rdata = cfg_to_word(cfg);
            ADDR_SEED: bus_rdata = seed_q;
            ADDR_RES:  bus_rdata = result_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R2: reserved configuration bits never read back
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CFG) |-> ((bus_rdata & ~CFG_MASK) == '0));

    // R9: seed writes leave the running CRC alone
    a_r9_seed_keeps_crc: assert property (@(posedge clk) disable iff (rst)
        seed_we |=> $stable(crc_q));

    // R10: result only moves on a data write
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        !din_we |=> $stable(result_q));

endmodule

// File: tb/crc_accel_test.sv
module crc_accel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    crc_accel uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // reference model state
    logic [31:0] m_seed, m_crc, m_res;
    logic [1:0]  m_start;
    logic        m_byte, m_cpl, m_omir, m_imir, m_pend;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b);
        logic fb;
        for (int k = 0; k < 8; k++) begin
            fb = c[31] ^ b[7-k];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic m_cfg_write(input logic [31:0] w);
        m_start = w[14:13]; m_byte = w[12]; m_cpl = w[9];
        m_omir = w[8]; m_imir = w[7]; m_pend = 1'b1;
        bus_write(4'h0, w);
    endtask

    task automatic m_din_write(input logic [31:0] d);
        logic [31:0] c;
        logic [7:0]  b;
        c = m_crc;
        if (m_pend) begin
            if (m_start == 2'd0) c = m_seed;
            else if (m_start == 2'd2) c = 32'h0;
            else if (m_start == 2'd3) c = 32'hFFFF_FFFF;
        end
        for (int i = 0; i < (m_byte ? 1 : 4); i++) begin
            b = d[8*i +: 8];
            if (m_imir) b = rev8(b);
            c = ref_step(c, b);
        end
        m_crc = c;
        for (int i = 0; i < 4; i++)
            m_res[8*i +: 8] = (m_omir ? rev8(c[8*i +: 8]) : c[8*i +: 8]) ^ {8{m_cpl}};
        m_pend = 1'b0;
        m_start = 2'd0;
        bus_write(4'h8, d);
    endtask

    function automatic logic [31:0] m_cfg_word();
        return {17'd0, m_start, m_byte, 2'b00, m_cpl, m_omir, m_imir, 7'd0};
    endfunction

    initial begin
        #(10 * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] word;
        m_seed = 0; m_crc = 0; m_res = 0; m_start = 0;
        m_byte = 0; m_cpl = 0; m_omir = 0; m_imir = 0; m_pend = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(4'h0, v); chk("R1 cfg", v, 32'h0);
        bus_read(4'h4, v); chk("R1 seed", v, 32'h0);
        bus_read(4'hC, v); chk("R1 result", v, 32'h0);

        // R2 reserved bits
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, v); chk("R2 all ones", v, 32'h0000_7380);
        bus_write(4'h0, 32'h0000_8C7F);
        bus_read(4'h0, v); chk("R2 only reserved", v, 32'h0);

        // R5 known vector, byte mode, start all ones
        m_cfg_write(32'h0000_7000);
        for (int i = 0; i < 9; i++) m_din_write(32'h0000_0031 + i);
        bus_read(4'hC, v); chk("R5 check vector", v, 32'h0376_E6E7);

        // sweep: every mode bit combination against every start code
        for (int mode = 0; mode < 16; mode++) begin
            for (int sc = 0; sc < 4; sc++) begin
                logic [31:0] w;
                w = {17'd0, sc[1:0], mode[0], 2'b00, mode[1], mode[2], mode[3], 7'd0};
                m_seed = 32'h5A00_0000 ^ (mode * 32'h0101_0101) ^ (sc * 32'h1357_9BDF);
                bus_write(4'h4, m_seed);
                bus_read(4'h4, v); chk("R9 seed readback", v, m_seed);
                m_cfg_write(w);
                bus_read(4'h0, v); chk("R2 cfg readback", v, m_cfg_word());
                for (int k = 0; k < 3; k++) begin
                    word = ((mode * 16 + sc * 4 + k + 1) * 32'h9E37_79B9) ^ 32'hC3A5_0F1E;
                    m_din_write(word);
                    bus_read(4'hC, v);
                    chk(k == 0 ? "R3 start value" : "R4 accumulate (R5 R6 R7 R8)", v, m_res);
                    if (k == 0) begin
                        bus_read(4'h0, v); chk("R4 start field cleared", v, m_cfg_word());
                    end
                    if (k == 1) begin
                        // R9: seed write mid-stream must not restart
                        m_seed = ~m_seed;
                        bus_write(4'h4, m_seed);
                        bus_read(4'hC, v); chk("R9 result after seed write", v, m_res);
                    end
                end
            end
        end

        // R10 result read-only
        bus_write(4'hC, ~m_res);
        bus_read(4'hC, v); chk("R10 write ignored", v, m_res);
        m_din_write(32'h1234_5678);
        bus_read(4'hC, v); chk("R10 next update", v, m_res);

        // R5 every byte value, byte mode, zero start, with mirrors and complement
        for (int b = 0; b < 256; b++) begin
            m_cfg_write(b[0] ? 32'h0000_5380 : 32'h0000_5000);
            m_din_write({24'hABCDEF, b[7:0]});
            bus_read(4'hC, v); chk("R5 byte sweep (R6 R7 R8)", v, m_res);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule